// File: doc/BRIEF.md
# Priority Interrupt Controller with Claim Lockout

This block collects level-sensitive interrupt lines from up to `NSRC - 1` sources, numbered from 1, and raises a single request line toward one processor core. Each source has a pending flag, a claimed flag, an enable bit and a 3-bit priority level. A global threshold masks every level at or below it. Every cycle, a combinational arbiter picks the enabled, pending source with the strictly highest priority above the threshold. When two or more candidates share that priority, the lowest ID wins.

Software talks to the block through a simple word-addressed read/write port. A read of the claim register returns the winning ID and moves that source from pending to claimed. While a source is claimed, its line cannot make it pending again. Writing the ID back to the same register completes the service and lifts the lockout. Every register change lands at the clock edge of the access. The request output is therefore correct in the cycle right after any claim, completion, priority, enable or threshold write.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending, claimed, enable, priority and threshold state is zero, `irq_o` is low, and every register reads 0.
- R2: The priority register for source k sits at byte address 4*(k-1) from `PRIO_BASE`. A write keeps only bits 2:0 of the data, giving levels 0 to 7, and a read returns that level in bits 2:0.
- R3: When a source line is high at a clock edge and the source is not claimed, its pending flag is set at that edge. The pending word at `PEND_BASE` + 4*w holds source 32*w+b in bit b, and bit 0 of word 0 always reads 0.
- R4: The enable word at `EN_BASE` + 4*w gates source 32*w+b through bit b. A disabled source stays pending but is never selected.
- R5: A source qualifies only if its priority is strictly greater than the threshold. The threshold register is at `THR_ADDR` and holds bits 2:0.
- R6: Among qualifying sources, the highest priority wins, and on a tie the lowest ID wins.
- R7: `irq_o` is high exactly when a non-zero source is selected. A read of the claim register at `CLAIM_ADDR` returns the selected ID on `bus_rdata` in the cycle after the read.
- R8: A claim read with a non-zero result clears that source's pending flag and sets its claimed flag. While it stays claimed, a high line does not make it pending again.
- R9: A claim read when nothing is selected returns 0 and changes no pending or claimed state.
- R10: Writing an ID below `NSRC` to the claim register clears that source's claimed flag, so a still-high line makes it pending again at the next edge. Writing the ID of a source that is not claimed has no effect.
- R11: Selection and `irq_o` reflect each claim, completion, priority, enable and threshold write in the cycle right after that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level interrupt lines; bit n is source n, and bit 0 is ignored |
| bus_en | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The directed pattern uses two sources at the same top level. It shows lowest-ID tie-breaking, and then shows that claimed lines stay quiet while they are still asserted. Threshold steps of 6 and 7 on a level-7 source probe the strict comparison. A line held high while its source is disabled separates "pending" from "selected". A second pattern lowers the winner's priority while it is pending, which checks that the output drops at once. The random phase mixes line changes, priority, enable and threshold writes, claims and completions across all sources. It compares every read and the request line with a bench model. That exposes ordering errors between claim, lockout and completion that the directed pattern cannot reach.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int WORD_W = 32;
    localparam int PRIO_W = 3;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PRIO,
        REG_EN,
        REG_PEND,
        REG_THR,
        REG_CLAIM
    } reg_kind_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int NSRC       = 64,
    parameter int ADDR_W     = 12,
    parameter int PRIO_BASE  = 'h000,
    parameter int EN_BASE    = 'h100,
    parameter int PEND_BASE  = 'h180,
    parameter int THR_ADDR   = 'h1C0,
    parameter int CLAIM_ADDR = 'h1C4,
    localparam int IDX_W     = $clog2(NSRC)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int NWORDS = (NSRC + WORD_W - 1) / WORD_W;

    int unsigned a;

    always_comb begin
        a    = 32'(addr);
        kind = REG_NONE;
        idx  = '0;
        if (a >= PRIO_BASE && a < PRIO_BASE + 4 * (NSRC - 1)) begin
            kind = REG_PRIO;
            idx  = IDX_W'((a - PRIO_BASE) / 4 + 1);
        end else if (a >= EN_BASE && a < EN_BASE + 4 * NWORDS) begin
            kind = REG_EN;
            idx  = IDX_W'((a - EN_BASE) / 4);
        end else if (a >= PEND_BASE && a < PEND_BASE + 4 * NWORDS) begin
            kind = REG_PEND;
            idx  = IDX_W'((a - PEND_BASE) / 4);
        end else if (a == THR_ADDR) begin
            kind = REG_THR;
        end else if (a == CLAIM_ADDR) begin
            kind = REG_CLAIM;
        end
    end
endmodule

// File: rtl/irqc_src_state.sv
module irqc_src_state #(
    parameter int NSRC    = 64,
    localparam int IDX_W  = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             take_fire,
    input  logic [IDX_W-1:0] take_id,
    input  logic             done_fire,
    input  logic [IDX_W-1:0] done_id,
    output logic [NSRC-1:0]  pend,
    output logic [NSRC-1:0]  claimed
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == 0) begin : g_none
            assign pend[i]    = 1'b0;
            assign claimed[i] = 1'b0;
        end else begin : g_line
            logic p_q;
            logic c_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    p_q <= 1'b0;
                    c_q <= 1'b0;
                end else if (take_fire && take_id == IDX_W'(i)) begin
                    p_q <= 1'b0;
                    c_q <= 1'b1;
                end else begin
                    if (src_i[i] && !c_q) begin
                        p_q <= 1'b1;
                    end
                    if (done_fire && done_id == IDX_W'(i)) begin
                        c_q <= 1'b0;
                    end
                end
            end
            assign pend[i]    = p_q;
            assign claimed[i] = c_q;
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NSRC    = 64,
    localparam int IDX_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]              pend,
    input  logic [NSRC-1:0]              en,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio,
    input  logic [PRIO_W-1:0]            thr,
    output logic [IDX_W-1:0]             win_id
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        best   = thr;
        win_id = '0;
        for (int i = 1; i < NSRC; i++) begin
            if (pend[i] && en[i] && prio[i] > best) begin
                best   = prio[i];
                win_id = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NSRC       = 64,
    parameter int ADDR_W     = 12,
    parameter int PRIO_BASE  = 'h000,
    parameter int EN_BASE    = 'h100,
    parameter int PEND_BASE  = 'h180,
    parameter int THR_ADDR   = 'h1C0,
    parameter int CLAIM_ADDR = 'h1C4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(NSRC);

    reg_kind_e                    kind;
    logic [IDX_W-1:0]             idx;
    logic [IDX_W-1:0]             sel_id;
    logic [NSRC-1:0]              pend;
    logic [NSRC-1:0]              claimed;
    logic [NSRC-1:0]              en_q;
    logic [NSRC-1:0][PRIO_W-1:0]  prio_q;
    logic [PRIO_W-1:0]            thr_q;
    logic [31:0]                  rdata_q;
    logic [WORD_W-1:0]            en_word;
    logic [WORD_W-1:0]            pend_word;
    logic                         rd_acc;
    logic                         wr_acc;
    logic                         take_fire;
    logic                         done_fire;

    irqc_decode #(
        .NSRC(NSRC), .ADDR_W(ADDR_W), .PRIO_BASE(PRIO_BASE), .EN_BASE(EN_BASE),
        .PEND_BASE(PEND_BASE), .THR_ADDR(THR_ADDR), .CLAIM_ADDR(CLAIM_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind),
        .idx (idx)
    );

    assign rd_acc    = bus_en && !bus_we;
    assign wr_acc    = bus_en && bus_we;
    assign take_fire = rd_acc && kind == REG_CLAIM && sel_id != '0;
    assign done_fire = wr_acc && kind == REG_CLAIM && bus_wdata < 32'(NSRC);

    irqc_src_state #(.NSRC(NSRC)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .take_fire(take_fire),
        .take_id  (sel_id),
        .done_fire(done_fire),
        .done_id  (bus_wdata[IDX_W-1:0]),
        .pend     (pend),
        .claimed  (claimed)
    );

    irqc_arbiter #(.NSRC(NSRC)) u_arb (
        .pend  (pend),
        .en    (en_q),
        .prio  (prio_q),
        .thr   (thr_q),
        .win_id(sel_id)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            prio_q <= '0;
            thr_q  <= '0;
        end else if (wr_acc) begin
            case (kind)
                REG_PRIO: prio_q[idx] <= bus_wdata[PRIO_W-1:0];
                REG_THR:  thr_q       <= bus_wdata[PRIO_W-1:0];
                REG_EN: begin
                    for (int i = 1; i < NSRC; i++) begin
                        if (i / WORD_W == int'(idx)) begin
                            en_q[i] <= bus_wdata[i % WORD_W];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        en_word   = '0;
        pend_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (i / WORD_W == int'(idx)) begin
                en_word[i % WORD_W]   = en_q[i];
                pend_word[i % WORD_W] = pend[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_acc) begin
            case (kind)
                REG_PRIO:  rdata_q <= 32'(prio_q[idx]);
                REG_EN:    rdata_q <= 32'(en_word);
                REG_PEND:  rdata_q <= 32'(pend_word);
                REG_THR:   rdata_q <= 32'(thr_q);
                REG_CLAIM: rdata_q <= 32'(sel_id);
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_o     = sel_id != '0;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int NSRC   = 64,
    localparam int IDX_W = $clog2(NSRC)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        irq_o,
    input logic                        bus_en,
    input logic                        bus_we,
    input reg_kind_e                   kind,
    input logic [31:0]                 bus_rdata,
    input logic [IDX_W-1:0]            sel_id,
    input logic [NSRC-1:0]             pend,
    input logic [NSRC-1:0]             claimed,
    input logic [NSRC-1:0]             en_q,
    input logic [NSRC-1:0][PRIO_W-1:0] prio_q,
    input logic [PRIO_W-1:0]           thr_q
);
    logic claim_rd;
    assign claim_rd = bus_en && !bus_we && kind == REG_CLAIM;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (pend & en_q) != '0); // R7
    AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n) (sel_id != '0) |-> prio_q[sel_id] > thr_q); // R5
    AST_CLAIM_RETURNS_ID: assert property (@(posedge clk) disable iff (!rst_n) claim_rd |=> bus_rdata == 32'($past(sel_id))); // R7
    AST_CLAIM_MOVES_STATE: assert property (@(posedge clk) disable iff (!rst_n) (claim_rd && sel_id != '0) |=> claimed[$past(sel_id)] && !pend[$past(sel_id)]); // R8
    AST_CLAIMED_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n) (pend & ~$past(pend) & $past(claimed)) == '0); // R8
    AST_EMPTY_CLAIM: assert property (@(posedge clk) disable iff (!rst_n) (claim_rd && sel_id == '0) |=> $stable(claimed) && bus_rdata == '0); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .kind     (kind),
    .bus_rdata(bus_rdata),
    .sel_id   (sel_id),
    .pend     (pend),
    .claimed  (claimed),
    .en_q     (en_q),
    .prio_q   (prio_q),
    .thr_q    (thr_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 64;
    localparam int EN_B  = 'h100;
    localparam int PND_B = 'h180;
    localparam int THR_A = 'h1C0;
    localparam int CLM_A = 'h1C4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [63:0] m_pend, m_claimed, m_en;
    int          m_prio [64];
    int          m_thr;
    logic [31:0] m_rd;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_sel();
        int best = m_thr;
        int id = 0;
        for (int i = 1; i < NSRC; i++)
            if (m_pend[i] && m_en[i] && m_prio[i] > best) begin
                best = m_prio[i];
                id = i;
            end
        return id;
    endfunction

    function automatic logic [31:0] exp_read(int a);
        if (a < 4 * (NSRC - 1)) return 32'(m_prio[a / 4 + 1]);
        if (a == EN_B) return m_en[31:0];
        if (a == EN_B + 4) return m_en[63:32];
        if (a == PND_B) return m_pend[31:0];
        if (a == PND_B + 4) return m_pend[63:32];
        if (a == THR_A) return 32'(m_thr);
        if (a == CLM_A) return 32'(exp_sel());
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        int a;
        int s;
        a = int'(bus_addr);
        s = 0;
        if (!rst_n) begin
            m_pend = '0; m_claimed = '0; m_en = '0; m_thr = 0; m_rd = '0;
            for (int i = 0; i < 64; i++) m_prio[i] = 0;
        end else begin
            if (bus_en && !bus_we) begin
                m_rd = exp_read(a);
                if (a == CLM_A) begin
                    s = exp_sel();
                    if (s != 0) begin
                        m_pend[s] = 1'b0;
                        m_claimed[s] = 1'b1;
                    end
                end
            end
            for (int i = 1; i < NSRC; i++)
                if (i != s && src[i] && !m_claimed[i]) m_pend[i] = 1'b1;
            if (bus_en && bus_we) begin
                if (a < 4 * (NSRC - 1)) m_prio[a / 4 + 1] = int'(bus_wdata[2:0]);
                else if (a == EN_B) m_en[31:0] = bus_wdata & 32'hFFFF_FFFE;
                else if (a == EN_B + 4) m_en[63:32] = bus_wdata;
                else if (a == THR_A) m_thr = int'(bus_wdata[2:0]);
                else if (a == CLM_A && bus_wdata < NSRC) m_claimed[bus_wdata] = 1'b0;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = 12'(a);
        @(negedge clk);
        d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        rd(PND_B, v);  chk("R1 pending", v, 0);
        rd(THR_A, v);  chk("R1 threshold", v, 0);
        rd(EN_B + 4, v); chk("R1 enable", v, 0);
        rd(4 * 9, v);  chk("R1 priority", v, 0);
        rd(CLM_A, v);  chk("R9 empty claim", v, 0);

        // R2 priority truncation and addressing
        wr(4 * 4, 32'hFF);  rd(4 * 4, v);  chk("R2 prio src5", v, 7);
        wr(4 * 62, 32'h0A); rd(4 * 62, v); chk("R2 prio src63", v, 2);

        // R3 / R4: pending while disabled
        src[5] = 1; idle();
        rd(PND_B, v); chk("R3 pending bit5", v, 32'h20);
        chk("R4 disabled not selected", 32'(irq_o), 0);
        wr(EN_B, 32'h28);
        chk("R4 enable selects", 32'(irq_o), 1);

        // R5 strict threshold
        wr(THR_A, 7); chk("R5 equal threshold masks", 32'(irq_o), 0);
        wr(THR_A, 6); chk("R5 below threshold passes", 32'(irq_o), 1);
        wr(THR_A, 0);

        // R6 tie, lowest ID wins
        wr(4 * 2, 7); src[3] = 1; idle();
        rd(CLM_A, v); chk("R6 tie lowest id", v, 3);
        chk("R7 irq still high", 32'(irq_o), 1);
        rd(CLM_A, v); chk("R7 claim returns 5", v, 5);
        chk("R11 irq drops after claims", 32'(irq_o), 0);
        idle(); idle();
        rd(PND_B, v); chk("R8 lockout while line high", v, 0);

        // R10 completion
        wr(CLM_A, 7); rd(PND_B, v); chk("R10 unclaimed id no effect", v, 0);
        wr(CLM_A, 3); idle();
        rd(PND_B, v); chk("R10 re-pend after complete", v, 32'h08);
        chk("R11 irq after complete", 32'(irq_o), 1);

        // R9 empty claim under threshold
        wr(THR_A, 7);
        rd(CLM_A, v); chk("R9 claim none", v, 0);
        rd(PND_B, v); chk("R9 pending unchanged", v, 32'h08);
        wr(THR_A, 0);

        // R11 priority write drops request at once
        wr(4 * 2, 0); chk("R11 prio write clears irq", 32'(irq_o), 0);
        wr(CLM_A, 5); src = '0;

        // random phase against model
        for (int it = 0; it < 1500; it++) begin
            int op;
            int id;
            op = int'($urandom % 7);
            id = 1 + int'($urandom % 63);
            if ($urandom % 4 == 0) src = {$urandom, $urandom} & {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFFE;
            case (op)
                0: wr(4 * (id - 1), $urandom);
                1: wr(EN_B + 4 * int'($urandom % 2), $urandom);
                2: wr(THR_A, $urandom % 5);
                3: begin rd(CLM_A, v); chk("R6 random claim", v, m_rd); end
                4: wr(CLM_A, (($urandom % 3) == 0) ? 32'($urandom % 70) : 32'(id));
                5: begin rd(PND_B + 4 * int'($urandom % 2), v); chk("R3 random pending", v, m_rd); end
                default: begin rd(4 * (id - 1), v); chk("R2 random prio", v, m_rd); end
            endcase
            chk("R7 random irq", 32'(irq_o), 32'(exp_sel() != 0));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule